// File: doc/BRIEF.md
# Linear Volume Scaler with Soft Mute

This block multiplies a stream of signed audio samples by a linear gain held as a 10-bit code, where the applied gain is the code divided by 1024. A sample is presented with a one-cycle valid strobe. The scaled result appears one clock later with its own valid strobe. Samples are 24-bit two's-complement words. Shorter 16-bit or 20-bit samples are carried MSB-aligned in that word with the unused low bits at zero. The same arithmetic therefore serves every word length.

The gain never jumps. An internal applied-gain register moves one code toward its target on each accepted sample. The target is the volume code input, or zero while mute is requested. A change of volume, muting and unmuting all fade in steps of 1/1024 of full scale, so no click is produced. Once the ramp into mute has reached zero, every output sample is exactly zero. A status output reports that state. After reset the applied gain is zero, so the first unmuted samples fade in from silence. Products are kept at full precision and then truncated toward zero. Because the gain never exceeds 1023/1024, the result always fits in the sample width.

Top module: `vol_ramp_scaler`

## Requirements
- R1: After reset, out_valid and out_sample are 0, mute_done is 0 while mute_req is 0, and the applied gain is 0. The first sample accepted after reset therefore produces 0.
- R2: out_valid is in_valid delayed by exactly one clock. When no sample is accepted, out_sample holds its previous value.
- R3: For a sample x accepted with applied gain g (the value before that sample's step), out_sample equals x*g/1024 truncated toward zero, as a 24-bit two's-complement value.
- R4: Each accepted sample moves the applied gain by exactly one code toward its target. Cycles without in_valid leave the gain unchanged.
- R5: The target is vol_code when mute_req is 0 and 0 when mute_req is 1. The gain stops once it equals the target.
- R6: While the mute ramp is complete, every accepted sample produces an output of exactly 0, full-scale inputs included.
- R7: mute_done is 1 exactly when mute_req is 1 and the applied gain is 0.
- R8: The magnitude of every output sample is at most the magnitude of the input that produced it, so no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_sample | input | 24 | Signed input sample, MSB-aligned |
| vol_code | input | 10 | Target gain code (gain = code/1024) |
| mute_req | input | 1 | Request a ramp down to zero gain |
| out_valid | output | 1 | Scaled sample is valid this cycle |
| out_sample | output | 24 | Signed scaled sample |
| mute_done | output | 1 | Mute requested and gain has reached zero |

## Verification
A sample driven with in_valid at one rising edge has its scaled result and out_valid due after that same edge's register stage. At that point the applied gain and mute_done already reflect that sample's step. The bench drives inputs on the falling edge and reads all three results on the following falling edge. It predicts each value from a gain model that is updated only when a sample is sent. The bench sweeps the gain through all 1024 codes while feeding varied and full-scale samples. It then ramps down to a lower code, ramps into mute and holds there, and confirms that idle cycles change neither the output nor the gain seen by the next sample.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  localparam int unsigned VRS_DATA_W = 24;
  localparam int unsigned VRS_GAIN_W = 10;

  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/vrs_gain_step.sv
module vrs_gain_step
  import vrs_pkg::*;
#(
  parameter int unsigned GAIN_W = VRS_GAIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [GAIN_W-1:0] target,
  output logic [GAIN_W-1:0] gain_q
);
  localparam logic [GAIN_W-1:0] ONE = GAIN_W'(1);

  ramp_dir_e         dir;
  logic [GAIN_W-1:0] gain_d;

  always_comb begin
    if (gain_q < target)      dir = RAMP_UP;
    else if (gain_q > target) dir = RAMP_DOWN;
    else                      dir = RAMP_HOLD;
  end

  always_comb begin
    gain_d = gain_q;
    if (step_en) begin
      case (dir)
        RAMP_UP:   gain_d = gain_q + ONE;
        RAMP_DOWN: gain_d = gain_q - ONE;
        default:   gain_d = gain_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gain_q <= '0;
    else if (step_en) gain_q <= gain_d;
  end
endmodule

// File: rtl/vrs_scale_mul.sv
module vrs_scale_mul
  import vrs_pkg::*;
#(
  parameter int unsigned DATA_W = VRS_DATA_W,
  parameter int unsigned GAIN_W = VRS_GAIN_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] sample,
  input  logic        [GAIN_W-1:0] gain,
  output logic signed [DATA_W-1:0] y_q
);
  localparam int unsigned PROD_W = DATA_W + GAIN_W;
  localparam logic signed [PROD_W-1:0] BIAS = PROD_W'((1 << GAIN_W) - 1);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] biased;
  logic signed [DATA_W-1:0] y_d;

  // gain < 2^GAIN_W, so |prod| < 2^(PROD_W-1): the product fits without overflow
  always_comb begin
    prod   = $signed(sample) * $signed({1'b0, gain});
    // add 2^GAIN_W-1 to negative products so the arithmetic shift rounds toward zero
    biased = prod[PROD_W-1] ? (prod + BIAS) : prod;
    y_d    = DATA_W'(biased >>> GAIN_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  y_q <= '0;
    else if (en) y_q <= y_d;
  end
endmodule

// File: rtl/vol_ramp_scaler.sv
module vol_ramp_scaler
  import vrs_pkg::*;
#(
  parameter int unsigned DATA_W = VRS_DATA_W,
  parameter int unsigned GAIN_W = VRS_GAIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic [GAIN_W-1:0] vol_code,
  input  logic              mute_req,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample,
  output logic              mute_done
);
  logic [GAIN_W-1:0]        tgt;
  logic [GAIN_W-1:0]        gain_q;
  logic signed [DATA_W-1:0] y_q;
  logic                     valid_q;

  assign tgt = mute_req ? '0 : vol_code;

  vrs_gain_step #(.GAIN_W(GAIN_W)) u_gain (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (in_valid),
    .target  (tgt),
    .gain_q  (gain_q)
  );

  vrs_scale_mul #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_valid),
    .sample ($signed(in_sample)),
    .gain   (gain_q),
    .y_q    (y_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= in_valid;
  end

  assign out_valid  = valid_q;
  assign out_sample = y_q;
  assign mute_done  = mute_req && (gain_q == '0);
endmodule

// File: rtl/vrs_checker.sv
module vrs_checker #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned GAIN_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_sample,
  input logic              mute_req,
  input logic [GAIN_W-1:0] tgt,
  input logic [GAIN_W-1:0] gain_q,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_sample,
  input logic              mute_done
);
  function automatic longint mag(input logic [DATA_W-1:0] v);
    longint s;
    s = longint'($signed(v));
    return (s < 0) ? -s : s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r1: assert (!out_valid && gain_q == '0 && out_sample == '0)
        else $error("reset state wrong");
    end
  end

  p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sample)));
  p_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gain_q < tgt) |=> gain_q == $past(gain_q) + GAIN_W'(1));
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(gain_q));
  p_mute_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mute_req && gain_q != '0) |=> gain_q == $past(gain_q) - GAIN_W'(1));
  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mute_done) |=> out_sample == '0);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> mag(out_sample) <= mag($past(in_sample)));
endmodule

bind vol_ramp_scaler vrs_checker #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_sample  (in_sample),
  .mute_req   (mute_req),
  .tgt        (tgt),
  .gain_q     (gain_q),
  .out_valid  (out_valid),
  .out_sample (out_sample),
  .mute_done  (mute_done)
);

// File: tb/vol_ramp_scaler_tb_top.sv
module vol_ramp_scaler_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_sample;
  logic [9:0]  vol_code;
  logic        mute_req;
  logic        out_valid;
  logic [23:0] out_sample;
  logic        mute_done;

  int  n_chk  = 0;
  int  n_fail = 0;
  int  mg     = 0;
  bit  fin    = 0;
  logic [23:0] last_out;

  vol_ramp_scaler dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .vol_code(vol_code), .mute_req(mute_req), .out_valid(out_valid),
    .out_sample(out_sample), .mute_done(mute_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] x, input string tag);
    longint e, xs, ys;
    int tgt;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = x;
    xs  = longint'($signed(x));
    e   = (xs * mg) / 1024;           // integer division truncates toward zero
    tgt = mute_req ? 0 : int'(vol_code);
    if (mg < tgt) mg++;
    else if (mg > tgt) mg--;
    @(negedge clk);
    in_valid = 1'b0;
    ys = longint'($signed(out_sample));
    chk(out_valid == 1'b1, "R2", "out_valid after sample", out_valid, 1);
    chk(ys == e, tag, "scaled sample", ys, e);
    chk(mute_done == (mute_req && mg == 0), "R7", "mute_done", mute_done,
        (mute_req && mg == 0));
    chk(((ys < 0) ? -ys : ys) <= ((xs < 0) ? -xs : xs), "R8", "magnitude",
        ys, xs);
    last_out = out_sample;
  endtask

  function automatic logic [23:0] pat(input int i);
    case (i % 7)
      0: return 24'h7FFFFF;
      1: return 24'h800000;
      default: return 24'(i * 37199 + 91);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; vol_code = 10'd1023; mute_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(out_sample == '0, "R1", "out_sample in reset", out_sample, 0);
    chk(mute_done == 1'b0, "R1", "mute_done in reset", mute_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: first sample after reset is scaled by gain 0
    send(24'h7FFFFF, "R1");
    // R3 R4: full ramp from 1 up to 1023 with varied samples
    for (int i = 1; i < 1023; i++) send(pat(i), "R3");
    // R5: gain stays at the target of 1023
    for (int i = 0; i < 4; i++) send(pat(i), "R5");
    send(24'h800000, "R3");
    // R2 R4: idle cycles hold the output and the gain
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R2", "out_valid idle", out_valid, 0);
      chk(out_sample == last_out, "R2", "out_sample held", out_sample, last_out);
    end
    send(24'h7FFFFF, "R4");
    // R5: ramp down to a lower volume code
    vol_code = 10'd500;
    for (int i = 0; i < 530; i++) send(pat(i + 3), "R5");
    // R5 R7: ramp into mute
    mute_req = 1'b1;
    for (int i = 0; i < 500; i++) send(pat(i + 5), "R5");
    // R6: muted output is exactly zero
    for (int i = 0; i < 20; i++) send(pat(i), "R6");
    // R3: smallest nonzero gain, after unmuting to code 1
    vol_code = 10'd1;
    mute_req = 1'b0;
    send(24'h7FFFFF, "R3");
    send(24'h7FFFFF, "R3");
    send(24'h800000, "R3");
    send(24'hFFFC00, "R3");
    send(24'hFFFBFF, "R3");
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule